// File: doc/BRIEF.md
# DSP Dual-Pointer Address Generator

This block produces memory addresses for a DSP datapath whose address pointers live in a small register file. Three transfer paths run side by side. An X-memory path and a Y-memory path each do parallel 16-bit transfers, and a single-transfer path does word or longword load/store.

For every requested transfer, the path reads its pointer and index registers. It drives the effective address combinationally in the same cycle and writes the updated pointer back to the register file on the next rising clock edge. Each path has its own adder, so all three can run in the same cycle.

The X and Y paths only update after the access, and they step by a fixed 2. Software gets a decrement by loading -2 into the index register and using the add-index mode. The single-transfer path adds a pre-decrement mode, where the decremented pointer is the access address. Its step is 2 for words and 4 for longwords.

A load port writes any register directly, and a read port returns any register combinationally. Every request is taken in the cycle it is presented. There is no back-pressure: the block has no stall condition, so none of the request paths has a ready signal.

Top module: `dsp_agu_top`

## Requirements
- R1: On the X/Y path, mode 2'b00 (and the unused code 2'b11) leaves the pointer unchanged. The address is the pointer with bit 0 forced to zero.
- R2: Every X/Y update is post-update. The address driven in the request cycle is derived from the pointer value before the update.
- R3: X/Y mode 2'b10 adds 2 to the selected pointer at the clock edge that ends the request cycle.
- R4: X/Y mode 2'b01 adds the index register to the pointer: register 8 for X and register 9 for Y. An index of -2 (32'hFFFFFFFE) gives a decrement by 2.
- R5: x_sel=0/1 selects register 4/5 as the X pointer, and y_sel=0/1 selects register 6/7 as the Y pointer.
- R6: s_sel=0..3 selects registers 2..5 as the single-transfer pointer, with register 8 as index. s_mode 2'b00 means no update, 2'b01 means post-update add index, and 2'b10 means post-update increment. For these modes the address comes from the old pointer.
- R7: s_mode 2'b11 is pre-decrement. The pointer is reduced by the step, and that reduced value is both the access address (before masking) and the value written back.
- R8: s_long=0 gives a step of 2 and clears address bit 0. s_long=1 gives a step of 4 and clears address bits 1:0. The written-back pointer is never masked.
- R9: All paths update in the same cycle when they target different registers. When the single path and the X path target the same register, the single-path result is stored, even in its no-update mode.
- R10: ld_en writes ld_data into register ld_idx, unless a transfer writes that register in the same cycle, in which case the transfer value wins. rd_data always shows register rd_idx.
- R11: Pointer arithmetic is 32-bit two's complement and wraps on overflow or underflow.
- R12: While rst_n is low, every register is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| x_req | input | 1 | X transfer in this cycle |
| x_sel | input | 1 | X pointer select (reg 4 or 5) |
| x_mode | input | 2 | X update mode |
| x_addr | output | 32 | X effective address |
| y_req | input | 1 | Y transfer in this cycle |
| y_sel | input | 1 | Y pointer select (reg 6 or 7) |
| y_mode | input | 2 | Y update mode |
| y_addr | output | 32 | Y effective address |
| s_req | input | 1 | Single transfer in this cycle |
| s_sel | input | 2 | Single pointer select (reg 2..5) |
| s_mode | input | 2 | Single update mode |
| s_long | input | 1 | 1 = longword, 0 = word |
| s_addr | output | 32 | Single effective address |
| ld_en | input | 1 | Direct register load |
| ld_idx | input | 4 | Register to load |
| ld_data | input | 32 | Load value |
| rd_idx | input | 4 | Register to read |
| rd_data | output | 32 | Contents of register rd_idx |

## Verification
The bench targets these corner cases:
- An odd pointer on the word path and a longword pre-decrement. A design that forgets the low-bit masking, or masks the stored pointer, shows the wrong address or a corrupted register.
- Pre-decrement. A design that uses the old pointer as the address gives a result off by the step.
- A pointer of 32'hFFFFFFFE incremented to zero. A design that saturates or carries wrongly gives the wrong value.
- Collisions: the X path and the single path writing the same register, and a load racing a pointer update. A design with the wrong priority keeps the value from the losing writer.
- The unused X mode code. A design that decodes it as an update would move the pointer.

// File: rtl/dsp_agu_pkg.sv
package dsp_agu_pkg;
  typedef enum logic [1:0] {
    PM_HOLD   = 2'b00,
    PM_ADDIDX = 2'b01,
    PM_INC    = 2'b10,
    PM_RSVD   = 2'b11
  } post_mode_e;

  typedef enum logic [1:0] {
    SM_HOLD   = 2'b00,
    SM_ADDIDX = 2'b01,
    SM_INC    = 2'b10,
    SM_PREDEC = 2'b11
  } single_mode_e;

  localparam int unsigned REG_SPTR0 = 2;
  localparam int unsigned REG_XPTR0 = 4;
  localparam int unsigned REG_YPTR0 = 6;
  localparam int unsigned REG_XIDX  = 8;
  localparam int unsigned REG_YIDX  = 9;
  localparam int unsigned WORD_STEP = 2;
  localparam int unsigned LONG_STEP = 4;
endpackage

// File: rtl/dsp_agu_regfile.sv
module dsp_agu_regfile
  import dsp_agu_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned NREGS = 16,
  localparam int unsigned IW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_we,
  input  logic [IW-1:0] s_idx,
  input  logic [W-1:0]  s_val,
  input  logic          x_we,
  input  logic [IW-1:0] x_idx,
  input  logic [W-1:0]  x_val,
  input  logic          y_we,
  input  logic [IW-1:0] y_idx,
  input  logic [W-1:0]  y_val,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic [W-1:0]  ld_val,
  output logic [W-1:0]  regs_o [NREGS]
);
  logic [W-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic hit_s, hit_x, hit_y, hit_l;
    assign hit_s = s_we  && (s_idx  == IW'(g));
    assign hit_x = x_we  && (x_idx  == IW'(g));
    assign hit_y = y_we  && (y_idx  == IW'(g));
    assign hit_l = ld_en && (ld_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs_q[g] <= '0;
      else if (hit_s) regs_q[g] <= s_val;
      else if (hit_x) regs_q[g] <= x_val;
      else if (hit_y) regs_q[g] <= y_val;
      else if (hit_l) regs_q[g] <= ld_val;
    end
  end

  assign regs_o = regs_q;

  // R10
  ld_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !(s_we && s_idx == ld_idx) && !(x_we && x_idx == ld_idx) &&
     !(y_we && y_idx == ld_idx))
    |=> regs_q[$past(ld_idx)] == $past(ld_val));

  // R9
  single_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_we && x_we && s_idx == x_idx) |=> regs_q[$past(s_idx)] == $past(s_val));
endmodule

// File: rtl/dsp_agu_post_unit.sv
module dsp_agu_post_unit
  import dsp_agu_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned STEP = WORD_STEP
) (
  input  logic [W-1:0] ptr_i,
  input  logic [W-1:0] idx_i,
  input  post_mode_e   mode_i,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] wb_o
);
  always_comb begin
    case (mode_i)
      PM_ADDIDX: wb_o = ptr_i + idx_i;
      PM_INC:    wb_o = ptr_i + W'(STEP);
      default:   wb_o = ptr_i;
    endcase
  end

  assign addr_o = {ptr_i[W-1:1], 1'b0};
endmodule

// File: rtl/dsp_agu_single_unit.sv
module dsp_agu_single_unit
  import dsp_agu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] ptr_i,
  input  logic [W-1:0] idx_i,
  input  single_mode_e mode_i,
  input  logic         long_i,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] wb_o
);
  logic [W-1:0] step;
  logic [W-1:0] eff;

  assign step = long_i ? W'(LONG_STEP) : W'(WORD_STEP);

  always_comb begin
    case (mode_i)
      SM_ADDIDX: wb_o = ptr_i + idx_i;
      SM_INC:    wb_o = ptr_i + step;
      SM_PREDEC: wb_o = ptr_i - step;
      default:   wb_o = ptr_i;
    endcase
  end

  assign eff    = (mode_i == SM_PREDEC) ? wb_o : ptr_i;
  assign addr_o = long_i ? {eff[W-1:2], 2'b00} : {eff[W-1:1], 1'b0};
endmodule

// File: rtl/dsp_agu_top.sv
module dsp_agu_top
  import dsp_agu_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned NREGS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     x_req,
  input  logic                     x_sel,
  input  logic [1:0]               x_mode,
  output logic [W-1:0]             x_addr,
  input  logic                     y_req,
  input  logic                     y_sel,
  input  logic [1:0]               y_mode,
  output logic [W-1:0]             y_addr,
  input  logic                     s_req,
  input  logic [1:0]               s_sel,
  input  logic [1:0]               s_mode,
  input  logic                     s_long,
  output logic [W-1:0]             s_addr,
  input  logic                     ld_en,
  input  logic [$clog2(NREGS)-1:0] ld_idx,
  input  logic [W-1:0]             ld_data,
  input  logic [$clog2(NREGS)-1:0] rd_idx,
  output logic [W-1:0]             rd_data
);
  localparam int unsigned IW    = $clog2(NREGS);
  localparam int unsigned LANES = 2;

  logic [W-1:0]  rf [NREGS];
  logic [IW-1:0] x_idx, y_idx, s_idx;
  logic [W-1:0]  s_wb;

  logic [W-1:0]  lane_ptr  [LANES];
  logic [W-1:0]  lane_idx  [LANES];
  logic [1:0]    lane_mode [LANES];
  logic [W-1:0]  lane_addr [LANES];
  logic [W-1:0]  lane_wb   [LANES];

  assign x_idx = IW'(REG_XPTR0) + IW'(x_sel);
  assign y_idx = IW'(REG_YPTR0) + IW'(y_sel);
  assign s_idx = IW'(REG_SPTR0) + IW'(s_sel);

  assign lane_ptr[0]  = rf[x_idx];
  assign lane_idx[0]  = rf[REG_XIDX];
  assign lane_mode[0] = x_mode;
  assign lane_ptr[1]  = rf[y_idx];
  assign lane_idx[1]  = rf[REG_YIDX];
  assign lane_mode[1] = y_mode;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dsp_agu_post_unit #(.W(W), .STEP(WORD_STEP)) u_post (
      .ptr_i  (lane_ptr[g]),
      .idx_i  (lane_idx[g]),
      .mode_i (post_mode_e'(lane_mode[g])),
      .addr_o (lane_addr[g]),
      .wb_o   (lane_wb[g])
    );
  end

  dsp_agu_single_unit #(.W(W)) u_single (
    .ptr_i  (rf[s_idx]),
    .idx_i  (rf[REG_XIDX]),
    .mode_i (single_mode_e'(s_mode)),
    .long_i (s_long),
    .addr_o (s_addr),
    .wb_o   (s_wb)
  );

  dsp_agu_regfile #(.W(W), .NREGS(NREGS)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_we   (s_req),
    .s_idx  (s_idx),
    .s_val  (s_wb),
    .x_we   (x_req),
    .x_idx  (x_idx),
    .x_val  (lane_wb[0]),
    .y_we   (y_req),
    .y_idx  (y_idx),
    .y_val  (lane_wb[1]),
    .ld_en  (ld_en),
    .ld_idx (ld_idx),
    .ld_val (ld_data),
    .regs_o (rf)
  );

  assign x_addr  = lane_addr[0];
  assign y_addr  = lane_addr[1];
  assign rd_data = rf[rd_idx];

  // R1
  x_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_req && (x_mode == 2'b00 || x_mode == 2'b11) && !(s_req && s_idx == x_idx))
    |=> rf[$past(x_idx)] == $past(lane_ptr[0]));

  // R3
  x_inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_req && x_mode == 2'b10 && !(s_req && s_idx == x_idx))
    |=> rf[$past(x_idx)] == $past(lane_ptr[0]) + W'(2));

  // R7
  s_predec_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_req && s_mode == 2'b11)
    |=> ($past(s_long) ? {rf[$past(s_idx)][W-1:2], 2'b00}
                       : {rf[$past(s_idx)][W-1:1], 1'b0}) == $past(s_addr));
endmodule

// File: tb/dsp_agu_top_tb_top.sv
module dsp_agu_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        x_req = 0, x_sel = 0;
  logic [1:0]  x_mode = 0;
  logic        y_req = 0, y_sel = 0;
  logic [1:0]  y_mode = 0;
  logic        s_req = 0, s_long = 0;
  logic [1:0]  s_sel = 0, s_mode = 0;
  logic        ld_en = 0;
  logic [3:0]  ld_idx = 0, rd_idx = 0;
  logic [31:0] ld_data = 0;
  logic [31:0] x_addr, y_addr, s_addr, rd_data;

  dsp_agu_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .x_req(x_req), .x_sel(x_sel), .x_mode(x_mode), .x_addr(x_addr),
    .y_req(y_req), .y_sel(y_sel), .y_mode(y_mode), .y_addr(y_addr),
    .s_req(s_req), .s_sel(s_sel), .s_mode(s_mode), .s_long(s_long), .s_addr(s_addr),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m [16];

  int          q_kind [$];
  logic [31:0] q_val  [$];
  string       q_tag  [$];

  task automatic push(input int kind, input logic [31:0] v, input string tag);
    q_kind.push_back(kind); q_val.push_back(v); q_tag.push_back(tag);
  endtask

  function automatic logic [31:0] post_f(input logic [31:0] p, input logic [31:0] ix,
                                         input logic [1:0] md);
    case (md)
      2'b01:   return p + ix;
      2'b10:   return p + 32'd2;
      default: return p;
    endcase
  endfunction

  task automatic xfer(input bit xe, input bit xs, input logic [1:0] xm,
                      input bit ye, input bit ys, input logic [1:0] ym,
                      input bit se, input logic [1:0] ss, input logic [1:0] sm, input bit sl,
                      input bit le, input logic [3:0] li, input logic [31:0] lv,
                      input string tag);
    logic [31:0] nm [16];
    logic [31:0] p, st, nv, ef;
    @(posedge clk); #2;
    nm = m;
    if (le) nm[li] = lv;
    if (xe) begin
      p = m[4 + xs];
      push(0, {p[31:1], 1'b0}, tag);
      nm[4 + xs] = post_f(p, m[8], xm);
    end
    if (ye) begin
      p = m[6 + ys];
      push(1, {p[31:1], 1'b0}, tag);
      nm[6 + ys] = post_f(p, m[9], ym);
    end
    if (se) begin
      p  = m[2 + ss];
      st = sl ? 32'd4 : 32'd2;
      case (sm)
        2'b01:   nv = p + m[8];
        2'b10:   nv = p + st;
        2'b11:   nv = p - st;
        default: nv = p;
      endcase
      ef = (sm == 2'b11) ? nv : p;
      push(2, sl ? {ef[31:2], 2'b00} : {ef[31:1], 1'b0}, tag);
      nm[2 + ss] = nv;
    end
    x_req = xe; x_sel = xs; x_mode = xm;
    y_req = ye; y_sel = ys; y_mode = ym;
    s_req = se; s_sel = ss; s_mode = sm; s_long = sl;
    ld_en = le; ld_idx = li; ld_data = lv;
    m = nm;
  endtask

  task automatic rd(input logic [3:0] idx, input string tag);
    @(posedge clk); #2;
    x_req = 0; y_req = 0; s_req = 0; ld_en = 0;
    rd_idx = idx;
    push(3, m[idx], tag);
  endtask

  task automatic load(input logic [3:0] idx, input logic [31:0] v);
    xfer(0,0,0, 0,0,0, 0,0,0,0, 1, idx, v, "R10 load");
  endtask

  // monitor: compare queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q_kind.size() > 0) begin
        int k;
        logic [31:0] e, a;
        string t;
        k = q_kind.pop_front(); e = q_val.pop_front(); t = q_tag.pop_front();
        case (k)
          0: a = x_addr;
          1: a = y_addr;
          2: a = s_addr;
          default: a = rd_data;
        endcase
        n_cmp++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, a, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R12: reset state
    for (int i = 0; i < 16; i++) rd(4'(i), "R12 reset");

    load(2, 32'h0000_0100); load(3, 32'hFFFF_FFFE);
    load(4, 32'h0000_1000); load(5, 32'h0000_2001);
    load(6, 32'h0000_3000); load(7, 32'h0000_4000);
    load(8, 32'hFFFF_FFFE); load(9, 32'h0000_0006);
    rd(5, "R10 load readback");

    // R1 hold, R2 old address, R3 inc
    xfer(1,0,2'b00, 0,0,0, 0,0,0,0, 0,0,0, "R1 x hold");
    rd(4, "R1 x hold ptr");
    xfer(1,0,2'b10, 0,0,0, 0,0,0,0, 0,0,0, "R2 x post-inc addr");
    rd(4, "R3 x inc ptr");
    xfer(1,1,2'b00, 0,0,0, 0,0,0,0, 0,0,0, "R1 x odd masked");
    rd(5, "R1 odd ptr unmasked");
    // R4 decrement via -2 index
    xfer(1,0,2'b01, 0,0,0, 0,0,0,0, 0,0,0, "R4 x add idx");
    rd(4, "R4 x dec ptr");
    xfer(1,0,2'b11, 0,0,0, 0,0,0,0, 0,0,0, "R1 x rsvd mode");
    rd(4, "R1 rsvd ptr");
    // R5 Y select and R9 index
    xfer(0,0,0, 1,0,2'b01, 0,0,0,0, 0,0,0, "R5 y sel0 add");
    rd(6, "R4 y add idx ptr");
    xfer(0,0,0, 1,1,2'b10, 0,0,0,0, 0,0,0, "R5 y sel1 inc");
    rd(7, "R5 y sel1 ptr");
    // R7 pre-decrement, R8 sizes
    xfer(0,0,0, 0,0,0, 1,2'd0,2'b11,0, 0,0,0, "R7 s predec word");
    rd(2, "R7 predec ptr");
    xfer(0,0,0, 0,0,0, 1,2'd0,2'b11,1, 0,0,0, "R8 s predec long");
    rd(2, "R8 long ptr unmasked");
    // R11 wrap
    xfer(0,0,0, 0,0,0, 1,2'd1,2'b10,0, 0,0,0, "R11 s inc wrap");
    rd(3, "R11 wrap ptr");
    // R6 add index and select
    xfer(0,0,0, 0,0,0, 1,2'd3,2'b01,0, 0,0,0, "R6 s add idx");
    rd(5, "R6 s add ptr");
    xfer(0,0,0, 0,0,0, 1,2'd2,2'b10,1, 0,0,0, "R8 s inc long");
    rd(4, "R8 long inc ptr");
    xfer(0,0,0, 0,0,0, 1,2'd2,2'b00,1, 0,0,0, "R6 s hold long");
    rd(4, "R6 s hold ptr");
    // R9 parallel and collision
    xfer(1,1,2'b10, 1,1,2'b01, 1,2'd0,2'b10,1, 0,0,0, "R9 parallel");
    rd(5, "R9 parallel x");
    rd(7, "R9 parallel y");
    rd(2, "R9 parallel s");
    xfer(1,0,2'b10, 0,0,0, 1,2'd2,2'b01,0, 0,0,0, "R9 collision");
    rd(4, "R9 single wins");
    xfer(1,0,2'b10, 0,0,0, 1,2'd2,2'b00,0, 0,0,0, "R9 collision hold");
    rd(4, "R9 single hold wins");
    // R10 load vs pointer
    xfer(0,0,0, 1,0,2'b10, 0,0,0,0, 1,4'd6,32'hDEAD_BEEF, "R10 load race");
    rd(6, "R10 pointer wins");
    xfer(1,1,2'b00, 0,0,0, 0,0,0,0, 1,4'd10,32'h1234_5678, "R10 load other");
    rd(10, "R10 load lands");

    rd(0, "R12 untouched");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule